// File: doc/BRIEF.md
# Scaler Frame Control Slave

This block is the register-side control of a video scaler. Software writes a run enable, the output frame size and a pair of coefficient bank selectors through a small memory-mapped port. These writes land in a pending set that the datapath never sees directly. When the datapath raises its frame request and the run enable is set, the block accepts the frame. It copies the pending set into an active set that stays frozen until the next accepted frame, and it marks itself busy until the datapath reports the end of the frame.

Clearing the run enable never cuts a frame short. It only stops the next frame request from being accepted. The busy flag is the one readable register. A separate coefficient-write path passes writes on to the coefficient store. While a frame is running, the path blocks any write that would land in a bank the datapath is reading.

Top module: `scaler_ctrl`

## Requirements
- R1: After a synchronous reset, the run enable, busy flag, active width, height and bank selects, read data, acknowledge, coefficient write strobe and error flag are all zero.
- R2: A write to address 0 sets the run enable from wdata bit 0 alone. A write of 0xFFFFFFFE leaves the enable at 0, and a later frame request is not acknowledged.
- R3: When frame_req is high at a clock edge with the enable at 1 and busy at 0, frame_start_ack is 1 for exactly the following cycle. From that cycle, busy is 1 and the active outputs equal the pending values.
- R4: A frame request is not accepted while the enable is 0 or busy is 1. Clearing the enable during a frame leaves busy at 1 and the active outputs unchanged.
- R5: Busy returns to 0 the cycle after frame_done is sampled high. A read of address 1 returns busy in bit 0, with zeros above, on reg_rdata one cycle after reg_rd.
- R6: A read of any address other than 1 returns zero one cycle after reg_rd.
- R7: Address 2 sets the pending width and address 3 sets the pending height, each from wdata[15:0]. A write made during a frame does not reach the active outputs before the next accepted frame.
- R8: Address 4 sets the pending horizontal bank and address 5 the vertical bank. A write whose full 32-bit wdata is NBANK or more is ignored, and the previous bank is kept.
- R9: A coefficient write that is allowed appears on coef_we_o with the same bank, address and data one cycle later, and coef_err stays 0.
- R10: While busy is 1, a coefficient write to the active horizontal or the active vertical bank is dropped, and coef_err pulses in the following cycle. A write to a bank index of NBANK or more is always dropped with coef_err.
- R11: While busy is 0, a coefficient write to any bank below NBANK is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| frame_req | input | 1 | Datapath asks to start a frame |
| frame_done | input | 1 | Datapath reports the end of the frame |
| frame_start_ack | output | 1 | One-cycle acceptance pulse |
| act_width | output | 16 | Active output width in pixels |
| act_height | output | 16 | Active output height in pixels |
| act_hbank | output | BANK_W | Active horizontal coefficient bank |
| act_vbank | output | BANK_W | Active vertical coefficient bank |
| coef_wr | input | 1 | Coefficient write request |
| coef_bank | input | BANK_W | Target bank index |
| coef_addr | input | CA_W | Tap/phase address |
| coef_data | input | CD_W | Coefficient value |
| coef_we_o | output | 1 | Forwarded coefficient write strobe |
| coef_bank_o | output | BANK_W | Forwarded bank index |
| coef_addr_o | output | CA_W | Forwarded tap/phase address |
| coef_data_o | output | CD_W | Forwarded coefficient value |
| coef_err | output | 1 | Pulses when a coefficient write is dropped |

## Verification
A pending register holding a wrong value stays hidden until the next accepted frame. It then shows on the active outputs in the cycle that frame_start_ack is high, so every frame acceptance is followed by a full comparison of the active set. A wrong busy flag shows up in three places: in a read of address 1, in an acknowledge that arrives when it should not or fails to arrive, and in a coefficient write whose pass or drop decision flips. Each of these is visible one cycle after the stimulus that exposes it.

// File: rtl/scl_ctrl_pkg.sv
package scl_ctrl_pkg;
    localparam int DW   = 32;
    localparam int WH_W = 16;

    localparam logic [2:0] A_GO     = 3'd0;
    localparam logic [2:0] A_STATUS = 3'd1;
    localparam logic [2:0] A_WIDTH  = 3'd2;
    localparam logic [2:0] A_HEIGHT = 3'd3;
    localparam logic [2:0] A_HBANK  = 3'd4;
    localparam logic [2:0] A_VBANK  = 3'd5;
endpackage

// File: rtl/scl_pending_regs.sv
module scl_pending_regs
    import scl_ctrl_pkg::*;
#(
    parameter int NBANK  = 6,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              status_i,
    output logic              go_o,
    output logic [WH_W-1:0]   width_o,
    output logic [WH_W-1:0]   height_o,
    output logic [BANK_W-1:0] hbank_o,
    output logic [BANK_W-1:0] vbank_o,
    output logic [DW-1:0]     rdata_o
);
    typedef struct packed {
        logic              go;
        logic [WH_W-1:0]   w;
        logic [WH_W-1:0]   h;
        logic [BANK_W-1:0] hb;
        logic [BANK_W-1:0] vb;
        logic [DW-1:0]     rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic  bank_ok;

    assign bank_ok = (wdata < DW'(NBANK));

    always_comb begin
        s_d = s_q;
        s_d.rdata = '0;
        if (rd && addr == A_STATUS) s_d.rdata = DW'(status_i);
        if (wr) begin
            case (addr)
                A_GO:     s_d.go = wdata[0];
                A_WIDTH:  s_d.w  = wdata[WH_W-1:0];
                A_HEIGHT: s_d.h  = wdata[WH_W-1:0];
                A_HBANK:  if (bank_ok) s_d.hb = wdata[BANK_W-1:0];
                A_VBANK:  if (bank_ok) s_d.vb = wdata[BANK_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign go_o     = s_q.go;
    assign width_o  = s_q.w;
    assign height_o = s_q.h;
    assign hbank_o  = s_q.hb;
    assign vbank_o  = s_q.vb;
    assign rdata_o  = s_q.rdata;

    // R8
    bank_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(hbank_o) < NBANK) && (int'(vbank_o) < NBANK));
    // R6
    rd_other_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr != A_STATUS) |=> (rdata_o == '0));
    // R2
    go_bit_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_GO) |=> (go_o == $past(wdata[0])));
endmodule

// File: rtl/scl_frame_seq.sv
module scl_frame_seq
    import scl_ctrl_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_req,
    input  logic              frame_done,
    input  logic              go_i,
    input  logic [WH_W-1:0]   pw,
    input  logic [WH_W-1:0]   ph,
    input  logic [BANK_W-1:0] phb,
    input  logic [BANK_W-1:0] pvb,
    output logic              ack_o,
    output logic              status_o,
    output logic [WH_W-1:0]   aw,
    output logic [WH_W-1:0]   ah,
    output logic [BANK_W-1:0] ahb,
    output logic [BANK_W-1:0] avb
);
    typedef struct packed {
        logic              ack;
        logic              busy;
        logic [WH_W-1:0]   w;
        logic [WH_W-1:0]   h;
        logic [BANK_W-1:0] hb;
        logic [BANK_W-1:0] vb;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    assign accept = frame_req && go_i && !s_q.busy;

    always_comb begin
        s_d = s_q;
        s_d.ack = accept;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.w    = pw;
            s_d.h    = ph;
            s_d.hb   = phb;
            s_d.vb   = pvb;
        end else if (frame_done) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ack_o    = s_q.ack;
    assign status_o = s_q.busy;
    assign aw       = s_q.w;
    assign ah       = s_q.h;
    assign ahb      = s_q.hb;
    assign avb      = s_q.vb;

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    // R3
    ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> status_o);
    // R4
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o && !frame_done) |=> status_o);
    // R7
    active_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> ($stable(aw) && $stable(ah) && $stable(ahb) && $stable(avb)));
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o && frame_done) |=> !status_o);
endmodule

// File: rtl/scl_coef_guard.sv
module scl_coef_guard #(
    parameter int NBANK  = 6,
    parameter int BANK_W = 3,
    parameter int CA_W   = 8,
    parameter int CD_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              status_i,
    input  logic [BANK_W-1:0] act_hb,
    input  logic [BANK_W-1:0] act_vb,
    input  logic              wr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [CA_W-1:0]   addr_i,
    input  logic [CD_W-1:0]   data_i,
    output logic              we_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [CA_W-1:0]   addr_o,
    output logic [CD_W-1:0]   data_o,
    output logic              err_o
);
    typedef struct packed {
        logic              we;
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [CA_W-1:0]   addr;
        logic [CD_W-1:0]   data;
    } cw_t;

    cw_t  s_d, s_q;
    logic in_use, in_range;

    assign in_range = (int'(bank_i) < NBANK);
    assign in_use   = status_i && (bank_i == act_hb || bank_i == act_vb);

    always_comb begin
        s_d     = s_q;
        s_d.we  = 1'b0;
        s_d.err = 1'b0;
        if (wr_i) begin
            if (in_range && !in_use) begin
                s_d.we   = 1'b1;
                s_d.bank = bank_i;
                s_d.addr = addr_i;
                s_d.data = data_i;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign we_o   = s_q.we;
    assign err_o  = s_q.err;
    assign bank_o = s_q.bank;
    assign addr_o = s_q.addr;
    assign data_o = s_q.data;

    // R10
    we_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(we_o && err_o));
    // R10
    active_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && status_i && (bank_i == act_hb || bank_i == act_vb)) |=> (err_o && !we_o));
    // R9
    fwd_chk: assert property (@(posedge clk) disable iff (rst)
        we_o |-> (bank_o == $past(bank_i) && data_o == $past(data_i) && $past(wr_i)));
endmodule

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
    import scl_ctrl_pkg::*;
#(
    parameter int NBANK  = 6,
    parameter int CA_W   = 8,
    parameter int CD_W   = 16,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_req,
    input  logic              frame_done,
    output logic              frame_start_ack,
    output logic [15:0]       act_width,
    output logic [15:0]       act_height,
    output logic [BANK_W-1:0] act_hbank,
    output logic [BANK_W-1:0] act_vbank,
    input  logic              coef_wr,
    input  logic [BANK_W-1:0] coef_bank,
    input  logic [CA_W-1:0]   coef_addr,
    input  logic [CD_W-1:0]   coef_data,
    output logic              coef_we_o,
    output logic [BANK_W-1:0] coef_bank_o,
    output logic [CA_W-1:0]   coef_addr_o,
    output logic [CD_W-1:0]   coef_data_o,
    output logic              coef_err
);
    logic              go, busy;
    logic [WH_W-1:0]   p_w, p_h;
    logic [BANK_W-1:0] p_hb, p_vb;

    scl_pending_regs #(.NBANK(NBANK), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .status_i(busy), .go_o(go), .width_o(p_w),
        .height_o(p_h), .hbank_o(p_hb), .vbank_o(p_vb), .rdata_o(reg_rdata)
    );

    scl_frame_seq #(.BANK_W(BANK_W)) u_seq (
        .clk(clk), .rst(rst), .frame_req(frame_req), .frame_done(frame_done),
        .go_i(go), .pw(p_w), .ph(p_h), .phb(p_hb), .pvb(p_vb),
        .ack_o(frame_start_ack), .status_o(busy), .aw(act_width),
        .ah(act_height), .ahb(act_hbank), .avb(act_vbank)
    );

    scl_coef_guard #(.NBANK(NBANK), .BANK_W(BANK_W), .CA_W(CA_W), .CD_W(CD_W)) u_guard (
        .clk(clk), .rst(rst), .status_i(busy), .act_hb(act_hbank),
        .act_vb(act_vbank), .wr_i(coef_wr), .bank_i(coef_bank),
        .addr_i(coef_addr), .data_i(coef_data), .we_o(coef_we_o),
        .bank_o(coef_bank_o), .addr_o(coef_addr_o), .data_o(coef_data_o),
        .err_o(coef_err)
    );

    // R4
    no_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_req && !go) |=> !frame_start_ack);
endmodule

// File: tb/sim_scaler_ctrl.sv
module sim_scaler_ctrl;
    localparam int NB = 6;
    localparam int BW = 3;

    logic clk = 0, rst = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic frame_req = 0, frame_done = 0, frame_start_ack;
    logic [15:0] act_width, act_height;
    logic [BW-1:0] act_hbank, act_vbank;
    logic coef_wr = 0;
    logic [BW-1:0] coef_bank = 0;
    logic [7:0] coef_addr = 0;
    logic [15:0] coef_data = 0;
    logic coef_we_o, coef_err;
    logic [BW-1:0] coef_bank_o;
    logic [7:0] coef_addr_o;
    logic [15:0] coef_data_o;

    int n_chk = 0, n_bad = 0;
    logic m_go = 0, m_busy = 0;
    logic [15:0] m_w = 0, m_h = 0, a_w = 0, a_h = 0;
    logic [BW-1:0] m_hb = 0, m_vb = 0, a_hb = 0, a_vb = 0;

    always #2 clk = ~clk;

    scaler_ctrl #(.NBANK(NB)) u0 (.*);

    function automatic logic [BW-1:0] exp_bank(input logic [BW-1:0] old, input logic [31:0] d);
        return (d < 32'(NB)) ? d[BW-1:0] : old;
    endfunction

    function automatic logic coef_ok(input logic [BW-1:0] b);
        return (int'(b) < NB) && !(m_busy && (b == a_hb || b == a_vb));
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_active(input string tag);
        chk(act_width == a_w, tag, act_width, a_w);
        chk(act_height == a_h, tag, act_height, a_h);
        chk(act_hbank == a_hb, tag, act_hbank, a_hb);
        chk(act_vbank == a_vb, tag, act_vbank, a_vb);
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
        case (a)
            3'd0: m_go = d[0];
            3'd2: m_w = d[15:0];
            3'd3: m_h = d[15:0];
            3'd4: m_hb = exp_bank(m_hb, d);
            3'd5: m_vb = exp_bank(m_vb, d);
            default: ;
        endcase
    endtask

    task automatic do_rd(input logic [2:0] a);
        logic [31:0] e;
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        e = (a == 3'd1) ? {31'b0, m_busy} : 32'b0;
        chk(reg_rdata == e, (a == 3'd1) ? "R5 status read" : "R6 zero read", reg_rdata, e);
    endtask

    task automatic do_frame();
        logic acc;
        acc = m_go && !m_busy;
        @(negedge clk); frame_req = 1;
        @(negedge clk); frame_req = 0;
        chk(frame_start_ack == acc, acc ? "R3 ack" : "R4 no ack", frame_start_ack, acc);
        if (acc) begin
            m_busy = 1; a_w = m_w; a_h = m_h; a_hb = m_hb; a_vb = m_vb;
        end
        chk_active("R7 R8 active set");
        @(negedge clk);
        chk(frame_start_ack == 0, "R3 one-cycle ack", frame_start_ack, 0);
    endtask

    task automatic do_done();
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
        m_busy = 0;
    endtask

    task automatic do_coef(input logic [BW-1:0] b, input logic [7:0] ad, input logic [15:0] dt);
        logic ok;
        ok = coef_ok(b);
        @(negedge clk); coef_wr = 1; coef_bank = b; coef_addr = ad; coef_data = dt;
        @(negedge clk); coef_wr = 0;
        chk(coef_we_o == ok, ok ? "R9 R11 forward" : "R10 drop", coef_we_o, ok);
        chk(coef_err == !ok, "R10 error flag", coef_err, !ok);
        if (ok) chk(coef_bank_o == b && coef_addr_o == ad && coef_data_o == dt,
                    "R9 payload", {coef_bank_o, coef_addr_o, coef_data_o}, {b, ad, dt});
    endtask

    initial begin
        #600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(frame_start_ack == 0 && reg_rdata == 0 && coef_we_o == 0 && coef_err == 0,
            "R1 reset outputs", {frame_start_ack, reg_rdata, coef_we_o, coef_err}, 0);
        chk_active("R1 active zero");
        do_rd(3'd1);
        do_frame();                       // R1: Go is 0 after reset
        // R2 only bit 0 counts
        do_wr(3'd0, 32'hFFFF_FFFE);
        do_frame();
        do_wr(3'd2, 32'hABCD_0280);
        do_wr(3'd3, 32'h0000_01E0);
        do_wr(3'd4, 32'd5);
        do_wr(3'd5, 32'd2);
        do_wr(3'd4, 32'd6);               // R8 ignored
        do_wr(3'd5, 32'h0000_0101);       // R8 ignored
        do_wr(3'd0, 32'd1);
        do_frame();                       // R3 accept
        do_rd(3'd1);
        do_frame();                       // R4 busy refuses
        // R7 mid-frame rewrite, R4 clear Go mid-frame
        do_wr(3'd2, 32'd1920);
        do_wr(3'd0, 32'd0);
        chk_active("R7 frozen mid-frame");
        do_rd(3'd1);
        // R10 active banks blocked, out of range blocked; R9 other bank allowed
        do_coef(3'd5, 8'h10, 16'h1234);
        do_coef(3'd2, 8'h11, 16'h5678);
        do_coef(3'd6, 8'h12, 16'h9ABC);
        do_coef(3'd0, 8'h13, 16'hDEF0);
        do_done();
        do_rd(3'd1);                      // R5 cleared
        do_frame();                       // R4 Go now 0
        do_coef(3'd5, 8'h20, 16'h1111);   // R11 idle write allowed
        do_rd(3'd0);
        do_rd(3'd6);
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1: do_wr(3'($urandom_range(0, 7)),
                            ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 8)) : $urandom());
                2:    do_wr(3'd0, 32'($urandom_range(0, 3)));
                3, 4: do_frame();
                5:    if (m_busy) do_done();
                6, 7: do_coef(3'($urandom_range(0, 7)), 8'($urandom()), 16'($urandom()));
                default: do_rd(3'($urandom_range(0, 7)));
            endcase
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule